// File: doc/BRIEF.md
# I2C Target Receive Engine with Buffer Writer

This block acts as a 7-bit addressed target on an I2C bus and stores the bytes a bus controller writes to it into a byte-wide memory. Software arms it with a single-cycle prepare-receive task and supplies a start pointer and a byte limit. The engine copies both into working registers when it accepts a write address, so software can set up the next transfer while this one runs. Further tasks stop, suspend and resume the engine. Single-cycle events report a receive start, a read request, a stop and an overflow.

Both bus lines are open-drain. The engine only ever pulls SCL or SDA low, and it observes both lines through synchronizers. It holds SCL low (clock stretching) in two cases: while software has it suspended, and while a matching write address waits for a prepare-receive task. Read transfers are recognised and acknowledged. Their data path is handled elsewhere.

Top module: `i2c_rx_engine`

## Requirements
- R1: When a write-direction address matching `own_addr` is accepted while prepared, SDA is driven low in the ninth clock (ACK), `evt_rx_started` pulses for one cycle, and the internal prepared flag clears. An address byte is {7-bit address, R/W}, sent MSB first, with R/W = 1 meaning read.
- R2: `cfg_ptr` and `cfg_maxcnt` are captured when `evt_rx_started` fires. Changing them later has no effect on the transfer in progress.
- R3: Each data byte received while the stored count is below the captured limit is ACKed and written once through `mem_we`/`mem_addr`/`mem_wdata`. The byte at index k goes to captured pointer + k. `rx_amount` reports the number of bytes stored in the last transfer.
- R4: A data byte received once the count has reached the limit is not written and not ACKed (SDA stays released), and `evt_error` pulses once for each such byte.
- R5: A repeated START during a receive ends it and returns the engine to the address phase without `evt_stopped`.
- R6: A STOP on the bus during a receive or read ends it. `evt_stopped` pulses, the prepared flag clears and the engine idles. A later matching write address is then stretched until a new prepare task.
- R7: `task_stop` ends any transfer at once. It raises `evt_stopped`, clears the prepared flag, releases both lines and ignores the bus until the next START.
- R8: After `task_suspend`, SCL is held low from the next moment it is low until `task_resume`. No byte is stored meanwhile.
- R9: A read-direction address match is ACKed and pulses `evt_read`. When `read_suspend_en` is 1, it also suspends the engine, so SCL stays low until `task_resume`.
- R10: A matching write address arriving while not prepared is neither ACKed nor NACKed. SCL is held low until `task_prepare_rx`, after which the address is ACKed and the receive starts.
- R11: A non-matching address is not ACKed, raises no event, and every following byte up to the next START or STOP is ignored.
- R12: After reset no line is pulled, no write is issued, every event is low and `rx_amount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| own_addr | input | 7 | Target address |
| cfg_ptr | input | ADDR_W | Buffer start address |
| cfg_maxcnt | input | CNT_W | Maximum bytes per transfer |
| read_suspend_en | input | 1 | Read request also suspends |
| task_prepare_rx | input | 1 | Arm for one receive |
| task_stop | input | 1 | Force end of transfer |
| task_suspend | input | 1 | Start stretching SCL |
| task_resume | input | 1 | Stop stretching SCL |
| evt_rx_started | output | 1 | Receive began (pulse) |
| evt_read | output | 1 | Read address matched (pulse) |
| evt_stopped | output | 1 | Transfer ended (pulse) |
| evt_error | output | 1 | Overflow byte NACKed (pulse) |
| rx_amount | output | CNT_W | Bytes stored in last transfer |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | ADDR_W | Buffer write address |
| mem_wdata | output | 8 | Buffer write byte |

## Verification
The bench's controller model addresses the engine in four ways:
- matching write while prepared, which separates the plain ACK path from the stretch-until-prepare path;
- matching write while not prepared;
- matching read, run with auto-suspend both off and on;
- a foreign address, which must leave the bus untouched.

Data streams run below the limit, across the limit and after a mid-transfer configuration change. These show whether the captured pointer and limit or the live registers steer the writes. Transfers end by bus STOP, by repeated START and by the stop task, and the count of stopped events separates these endings.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_RECV,
      ST_READ,
      ST_SKIP
   } rx_state_e;

   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned TADDR_BITS = 7;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
   assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_buf_writer.sv
module i2c_buf_writer #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_begin,
   input  logic [ADDR_W-1:0] cfg_ptr,
   input  logic [CNT_W-1:0]  cfg_maxcnt,
   input  logic              byte_push,
   input  logic [7:0]        byte_data,
   output logic              room,
   output logic [CNT_W-1:0]  amount,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);

   if (ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("i2c_buf_writer: widths must be positive");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic [CNT_W-1:0]  max_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] offs;

   if (ADDR_W >= CNT_W) begin : g_offs_ext
      assign offs = {{(ADDR_W-CNT_W){1'b0}}, cnt_q};
   end else begin : g_offs_trunc
      assign offs = cnt_q[ADDR_W-1:0];
   end

   assign room   = cnt_q < max_q;
   assign amount = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         max_q     <= '0;
         cnt_q     <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         if (xfer_begin) begin
            ptr_q <= cfg_ptr;
            max_q <= cfg_maxcnt;
            cnt_q <= '0;
         end else if (byte_push && room) begin
            mem_we    <= 1'b1;
            mem_addr  <= ptr_q + offs;
            mem_wdata <= byte_data;
            cnt_q     <= cnt_q + 1'b1;
         end
      end
   end

   AST_WRITE_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (cnt_q <= max_q)); // R4

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_begin |=> ($stable(ptr_q) && $stable(max_q))); // R2

endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
   import i2c_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic [6:0] own_addr,
   input  logic       read_suspend_en,
   input  logic       task_prepare_rx,
   input  logic       task_stop,
   input  logic       task_suspend,
   input  logic       task_resume,
   input  logic       room,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic       evt_rx_started,
   output logic       evt_read,
   output logic       evt_stopped,
   output logic       evt_error,
   output logic       byte_push,
   output logic [7:0] byte_data
);

   localparam int unsigned BITS_W = $clog2(BYTE_BITS + 1);
   localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(BYTE_BITS - 1);
   localparam logic [BITS_W-1:0] FULL_BYTE = BITS_W'(BYTE_BITS);

   rx_state_e         state;
   logic [7:0]        shreg;
   logic [BITS_W-1:0] bitcnt;
   logic              need_dec;
   logic              in_ack;
   logic              prepared;
   logic              suspended;
   logic              addr_hit;
   logic              is_read;
   logic              decide;
   logic              wait_prep;
   logic              stretch_req;
   logic              shifting;

   always_comb begin
      addr_hit    = (shreg[7:1] == own_addr);
      is_read     = shreg[0];
      decide      = need_dec && !scl_s && !in_ack;
      wait_prep   = (state == ST_ADDR) && need_dec && addr_hit && !is_read && !prepared;
      stretch_req = suspended | wait_prep;
      shifting    = (state == ST_ADDR) || (state == ST_RECV);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         shreg          <= '0;
         bitcnt         <= '0;
         need_dec       <= 1'b0;
         in_ack         <= 1'b0;
         prepared       <= 1'b0;
         suspended      <= 1'b0;
         scl_oe         <= 1'b0;
         sda_oe         <= 1'b0;
         evt_rx_started <= 1'b0;
         evt_read       <= 1'b0;
         evt_stopped    <= 1'b0;
         evt_error      <= 1'b0;
         byte_push      <= 1'b0;
         byte_data      <= '0;
      end else begin
         evt_rx_started <= 1'b0;
         evt_read       <= 1'b0;
         evt_stopped    <= 1'b0;
         evt_error      <= 1'b0;
         byte_push      <= 1'b0;
         scl_oe         <= stretch_req & (scl_oe | ~scl_s);

         if (task_prepare_rx) prepared <= 1'b1;
         if (task_resume)     suspended <= 1'b0;
         if (task_suspend)    suspended <= 1'b1;

         if (task_stop) begin
            state       <= ST_IDLE;
            sda_oe      <= 1'b0;
            scl_oe      <= 1'b0;
            in_ack      <= 1'b0;
            need_dec    <= 1'b0;
            prepared    <= 1'b0;
            suspended   <= 1'b0;
            evt_stopped <= 1'b1;
         end else if (bus_start) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            need_dec <= 1'b0;
            in_ack   <= 1'b0;
            sda_oe   <= 1'b0;
         end else if (bus_stop) begin
            if (state == ST_RECV || state == ST_READ) begin
               evt_stopped <= 1'b1;
               prepared    <= 1'b0;
            end
            state    <= ST_IDLE;
            need_dec <= 1'b0;
            in_ack   <= 1'b0;
            sda_oe   <= 1'b0;
         end else begin
            if (shifting && scl_rise && !in_ack && bitcnt < FULL_BYTE) begin
               shreg  <= {shreg[6:0], sda_s};
               bitcnt <= bitcnt + 1'b1;
               if (bitcnt == LAST_BIT) need_dec <= 1'b1;
            end

            if (decide && state == ST_ADDR) begin
               if (!addr_hit) begin
                  state    <= ST_SKIP;
                  need_dec <= 1'b0;
               end else if (is_read) begin
                  state    <= ST_READ;
                  need_dec <= 1'b0;
                  in_ack   <= 1'b1;
                  sda_oe   <= 1'b1;
                  evt_read <= 1'b1;
                  if (read_suspend_en) suspended <= 1'b1;
               end else if (prepared) begin
                  state          <= ST_RECV;
                  need_dec       <= 1'b0;
                  in_ack         <= 1'b1;
                  sda_oe         <= 1'b1;
                  evt_rx_started <= 1'b1;
                  prepared       <= 1'b0;
               end
            end else if (decide && state == ST_RECV) begin
               need_dec <= 1'b0;
               in_ack   <= 1'b1;
               if (room) begin
                  sda_oe    <= 1'b1;
                  byte_push <= 1'b1;
                  byte_data <= shreg;
               end else begin
                  evt_error <= 1'b1;
               end
            end

            if (scl_fall && in_ack) begin
               sda_oe <= 1'b0;
               in_ack <= 1'b0;
               bitcnt <= '0;
            end
         end
      end
   end

   AST_STARTED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rx_started |=> !evt_rx_started); // R1

   AST_PREP_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rx_started && !task_prepare_rx) |=> !prepared); // R1

   AST_NACK_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      evt_error |-> !sda_oe); // R4

   AST_RESTART_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && !task_stop) |=> !evt_stopped); // R5

   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stopped |-> (state == ST_IDLE)); // R6

   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && suspended && !task_resume && !task_stop) |=> scl_oe); // R8

   AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      evt_read |-> sda_oe); // R9

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [6:0]        own_addr,
   input  logic [ADDR_W-1:0] cfg_ptr,
   input  logic [CNT_W-1:0]  cfg_maxcnt,
   input  logic              read_suspend_en,
   input  logic              task_prepare_rx,
   input  logic              task_stop,
   input  logic              task_suspend,
   input  logic              task_resume,
   output logic              evt_rx_started,
   output logic              evt_read,
   output logic              evt_stopped,
   output logic              evt_error,
   output logic [CNT_W-1:0]  rx_amount,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);

   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       bus_start;
   logic       bus_stop;
   logic       room;
   logic       byte_push;
   logic [7:0] byte_data;
   logic       started;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   i2c_rx_ctrl u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_s           (scl_s),
      .sda_s           (sda_s),
      .scl_rise        (scl_rise),
      .scl_fall        (scl_fall),
      .bus_start       (bus_start),
      .bus_stop        (bus_stop),
      .own_addr        (own_addr),
      .read_suspend_en (read_suspend_en),
      .task_prepare_rx (task_prepare_rx),
      .task_stop       (task_stop),
      .task_suspend    (task_suspend),
      .task_resume     (task_resume),
      .room            (room),
      .scl_oe          (scl_oe),
      .sda_oe          (sda_oe),
      .evt_rx_started  (started),
      .evt_read        (evt_read),
      .evt_stopped     (evt_stopped),
      .evt_error       (evt_error),
      .byte_push       (byte_push),
      .byte_data       (byte_data)
   );

   assign evt_rx_started = started;

   i2c_buf_writer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_writer (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_begin (started),
      .cfg_ptr    (cfg_ptr),
      .cfg_maxcnt (cfg_maxcnt),
      .byte_push  (byte_push),
      .byte_data  (byte_data),
      .room       (room),
      .amount     (rx_amount),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );

   AST_ERROR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_error |-> !mem_we); // R4

endmodule

// File: tb/i2c_rx_engine_bench.sv
module i2c_rx_engine_bench;

   localparam int AW = 16;
   localparam int CW = 8;
   localparam int Q  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic m_scl_pull = 1'b0;
   logic m_sda_pull = 1'b0;
   logic scl_oe, sda_oe;
   logic scl_line, sda_line;
   assign scl_line = !(m_scl_pull | scl_oe);
   assign sda_line = !(m_sda_pull | sda_oe);

   logic [6:0]    own_addr = 7'h2A;
   logic [AW-1:0] cfg_ptr = 16'h0100;
   logic [CW-1:0] cfg_maxcnt = 8'd4;
   logic          read_suspend_en = 1'b0;
   logic          t_prep = 1'b0, t_stop = 1'b0, t_susp = 1'b0, t_res = 1'b0;
   logic          e_start, e_read, e_stop, e_err;
   logic [CW-1:0] rx_amount;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;

   i2c_rx_engine u_i2c_rx_engine (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
      .cfg_ptr(cfg_ptr), .cfg_maxcnt(cfg_maxcnt),
      .read_suspend_en(read_suspend_en), .task_prepare_rx(t_prep),
      .task_stop(t_stop), .task_suspend(t_susp), .task_resume(t_res),
      .evt_rx_started(e_start), .evt_read(e_read), .evt_stopped(e_stop),
      .evt_error(e_err), .rx_amount(rx_amount), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata)
   );

   int n_chk = 0;
   int n_err = 0;
   int c_start = 0, c_read = 0, c_stop = 0, c_err = 0, wr_seen = 0;

   typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic exp_push(logic [AW-1:0] a, logic [7:0] d);
      exp_q.push_back('{a: a, d: d});
   endtask

   // scoreboard monitor and event counters
   always @(negedge clk) begin
      if (rst_n) begin
         c_start += int'(e_start);
         c_read  += int'(e_read);
         c_stop  += int'(e_stop);
         c_err   += int'(e_err);
         if (mem_we) begin
            wr_t w;
            wr_seen++;
            n_chk++;
            if (exp_q.size() == 0) begin
               n_err++;
               $display("FAIL R3 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
            end else begin
               w = exp_q.pop_front();
               if (w.a != mem_addr || w.d != mem_wdata) begin
                  n_err++;
                  $display("FAIL R3 write actual=%0h:%0h expected=%0h:%0h",
                           mem_addr, mem_wdata, w.a, w.d);
               end
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   task automatic wq(); repeat (Q) @(negedge clk); endtask
   task automatic wait_high(); while (!scl_line) @(negedge clk); endtask

   task automatic bus_start();
      m_sda_pull = 1'b0; wq();
      m_scl_pull = 1'b0; wait_high(); wq();
      m_sda_pull = 1'b1; wq();
      m_scl_pull = 1'b1; wq();
   endtask

   task automatic bus_stop();
      m_sda_pull = 1'b1; wq();
      m_scl_pull = 1'b0; wait_high(); wq();
      m_sda_pull = 1'b0; wq();
      repeat (10) @(negedge clk);
   endtask

   task automatic xfer_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda_pull = !b[i]; wq();
         m_scl_pull = 1'b0; wait_high(); wq();
         m_scl_pull = 1'b1; wq();
      end
      m_sda_pull = 1'b0; wq();
      m_scl_pull = 1'b0; wait_high(); wq();
      ack = !sda_line;
      m_scl_pull = 1'b1; wq();
   endtask

   task automatic pulse_prep(); @(negedge clk) t_prep = 1'b1; @(negedge clk) t_prep = 1'b0; endtask
   task automatic pulse_stop(); @(negedge clk) t_stop = 1'b1; @(negedge clk) t_stop = 1'b0; endtask
   task automatic pulse_susp(); @(negedge clk) t_susp = 1'b1; @(negedge clk) t_susp = 1'b0; endtask
   task automatic pulse_res();  @(negedge clk) t_res  = 1'b1; @(negedge clk) t_res  = 1'b0; endtask

   initial begin
      logic ak;
      int w0;
      repeat (5) @(negedge clk);
      // R12 reset state
      chk("R12 scl_oe", scl_oe, 0);
      chk("R12 sda_oe", sda_oe, 0);
      chk("R12 mem_we", mem_we, 0);
      chk("R12 events", {e_start, e_read, e_stop, e_err}, 0);
      chk("R12 rx_amount", rx_amount, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R10: write address while not prepared stretches until prepare
      bus_start();
      fork
         xfer_byte({7'h2A, 1'b0}, ak);
         begin
            repeat (450) @(negedge clk);
            chk("R10 scl held before prepare", scl_line, 0);
            chk("R10 no start event yet", c_start, 0);
            pulse_prep();
         end
      join
      chk("R10 address ACK after prepare", ak, 1);
      chk("R1 rx_started event", c_start, 1);
      exp_push(16'h0100, 8'h11); xfer_byte(8'h11, ak); chk("R3 ack byte0", ak, 1);
      exp_push(16'h0101, 8'h22); xfer_byte(8'h22, ak); chk("R3 ack byte1", ak, 1);
      cfg_ptr = 16'h0300; cfg_maxcnt = 8'd1;
      exp_push(16'h0102, 8'h33); xfer_byte(8'h33, ak); chk("R2 config change ignored", ak, 1);
      bus_stop();
      chk("R6 stopped on bus stop", c_stop, 1);
      chk("R3 rx_amount", rx_amount, 3);
      chk("R3 writes seen", wr_seen, 3);

      // R4 overflow
      cfg_ptr = 16'h0200; cfg_maxcnt = 8'd2;
      pulse_prep();
      bus_start();
      xfer_byte({7'h2A, 1'b0}, ak); chk("R1 prepared address ACK", ak, 1);
      chk("R1 second start event", c_start, 2);
      exp_push(16'h0200, 8'hA1); xfer_byte(8'hA1, ak); chk("R3 ack A1", ak, 1);
      exp_push(16'h0201, 8'hB2); xfer_byte(8'hB2, ak); chk("R3 ack B2", ak, 1);
      xfer_byte(8'hC3, ak); chk("R4 overflow NACK C3", ak, 0);
      xfer_byte(8'hD4, ak); chk("R4 overflow NACK D4", ak, 0);
      chk("R4 error events", c_err, 2);
      chk("R4 amount at limit", rx_amount, 2);
      bus_stop();
      chk("R6 stopped count", c_stop, 2);

      // R6 prepared cleared; R5 repeated start; R11 foreign address
      bus_start();
      fork
         xfer_byte({7'h2A, 1'b0}, ak);
         begin
            repeat (450) @(negedge clk);
            chk("R6 prepare cleared, scl held", scl_line, 0);
            pulse_prep();
         end
      join
      exp_push(16'h0200, 8'h55); xfer_byte(8'h55, ak); chk("R3 ack 55", ak, 1);
      bus_start();
      chk("R5 no stopped on restart", c_stop, 2);
      xfer_byte({7'h13, 1'b0}, ak); chk("R11 foreign address NACK", ak, 0);
      xfer_byte(8'h66, ak); chk("R11 following byte ignored", ak, 0);
      bus_stop();
      chk("R11 no stopped after foreign", c_stop, 2);
      chk("R5 amount kept", rx_amount, 1);
      chk("R11 no extra events", c_start + c_read + c_err, 3 + 0 + 2);

      // R7 stop task
      pulse_prep();
      bus_start();
      xfer_byte({7'h2A, 1'b0}, ak);
      exp_push(16'h0200, 8'h77); xfer_byte(8'h77, ak); chk("R3 ack 77", ak, 1);
      pulse_stop();
      repeat (5) @(negedge clk);
      chk("R7 stopped by task", c_stop, 3);
      xfer_byte(8'h88, ak); chk("R7 bus ignored after stop task", ak, 0);
      bus_stop();
      chk("R7 no second stopped", c_stop, 3);

      // R8 suspend / resume
      pulse_prep();
      bus_start();
      xfer_byte({7'h2A, 1'b0}, ak);
      exp_push(16'h0200, 8'h99); xfer_byte(8'h99, ak);
      pulse_susp();
      w0 = wr_seen;
      exp_push(16'h0201, 8'hAB);
      fork
         xfer_byte(8'hAB, ak);
         begin
            repeat (300) @(negedge clk);
            chk("R8 scl held while suspended", scl_line, 0);
            chk("R8 no write while suspended", wr_seen, w0);
            pulse_res();
         end
      join
      chk("R8 ack after resume", ak, 1);
      bus_stop();
      chk("R8 stopped", c_stop, 4);

      // R9 read request
      bus_start();
      xfer_byte({7'h2A, 1'b1}, ak); chk("R9 read address ACK", ak, 1);
      chk("R9 read event", c_read, 1);
      bus_stop();
      chk("R9 stopped after read", c_stop, 5);
      read_suspend_en = 1'b1;
      bus_start();
      fork
         xfer_byte({7'h2A, 1'b1}, ak);
         begin
            repeat (450) @(negedge clk);
            chk("R9 auto suspend holds scl", scl_line, 0);
            pulse_res();
         end
      join
      chk("R9 auto-suspend ACK", ak, 1);
      chk("R9 second read event", c_read, 2);
      bus_stop();
      chk("R9 stopped", c_stop, 6);
      chk("R3 all expected writes seen", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule